// File: doc/BRIEF.md
# Two-Clock Request/Done Handshake Bridge

This block connects two systems that run on unrelated clocks. It carries a one-bit command level from a sending domain (A) to a receiving domain (B), and a one-bit completion level from B back to A. Each crossing level is launched from a flip-flop in its own domain. It is then resampled by a chain of synchronizing flip-flops clocked on the rising edge of the domain that receives it. Only single control bits cross; no data word travels through the bridge.

The two sides run a four-phase protocol. The sender raises its request and holds it until the returned done level is seen high, then drops it. The receiver raises done in answer to the request, and drops it once the request is seen low. The bridge enforces the ordering at both launch points. In domain A, a new request cannot start while the returned done is still high. In domain B, a completion cannot start while the delivered request is low. A held-off level is released as soon as the condition clears. Each domain has its own active-low reset, asserted asynchronously and released through a local reset synchronizer.

Top module: `cdc_req_done_bridge`

## Requirements
- R1: While either reset is asserted, and after both are released with all inputs low, b_req_o and a_done_o are 0.
- R2: A rise on a_req_i, with a_done_o low, produces a rise on b_req_o. The rise comes between SYNC_STAGES and SYNC_STAGES+3 rising clk_b edges after a_req_i was driven high. The request then stays high for as long as a_req_i stays high.
- R3: A fall on a_req_i produces a fall on b_req_o within SYNC_STAGES to SYNC_STAGES+3 rising clk_b edges, whatever the done level.
- R4: A rise on b_done_i, with b_req_o high, produces a rise on a_done_o within SYNC_STAGES to SYNC_STAGES+3 rising clk_a edges.
- R5: A fall on b_done_i produces a fall on a_done_o within SYNC_STAGES to SYNC_STAGES+3 rising clk_a edges, whatever the request level.
- R6: A rise on a_req_i while a_done_o is high does not reach b_req_o. Once a_done_o goes low, with a_req_i still high, b_req_o rises within SYNC_STAGES to SYNC_STAGES+3 clk_b edges.
- R7: A rise on b_done_i while b_req_o is low does not reach a_done_o. Once b_req_o goes high, with b_done_i still high, a_done_o rises within SYNC_STAGES to SYNC_STAGES+3 clk_a edges.
- R8: Over repeated complete four-phase cycles with varied response gaps, b_req_o and a_done_o each show exactly the expected alternating sequence of edges, with none lost and none extra. Both end low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Sending-domain clock |
| rst_a_n | input | 1 | Sending-domain asynchronous reset, active low |
| a_req_i | input | 1 | Request level from the sending system |
| a_done_o | output | 1 | Completion level, synchronized to clk_a |
| clk_b | input | 1 | Receiving-domain clock |
| rst_b_n | input | 1 | Receiving-domain asynchronous reset, active low |
| b_req_o | output | 1 | Request level, synchronized to clk_b |
| b_done_i | input | 1 | Completion level from the receiving system |

## Verification
The hardest situations to reach are the two hold-off cases. In one, the sender raises a fresh request while the old done is still returning high. In the other, the receiver raises done before any request has arrived. A cooperative sender and receiver never create either case. The bench therefore breaks protocol on purpose. It lowers the request and re-raises it at once while the receiver is made to keep done high. Separately, it raises done with no request pending. In both cases it checks that the far output stays quiet for many cycles, then releases the blocking level and measures the delayed edge. The two clocks have periods of 10 ns and 7.2 ns, so launch and capture edges drift against each other, and the latency checks allow for that drift.

// File: rtl/cdc_hs_pkg.sv
package cdc_hs_pkg;

  // Fewer than two resampling stages gives no settling time at all.
  localparam int unsigned MIN_STAGES = 2;
  localparam int unsigned DEF_STAGES = 2;

  function automatic int unsigned clamp_stages(input int unsigned n);
    return (n < MIN_STAGES) ? MIN_STAGES : n;
  endfunction

endpackage

// File: rtl/cdc_hs_rst_sync.sv
module cdc_hs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Assert at once, release only after STAGES clean edges.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/cdc_hs_sync_chain.sv
module cdc_hs_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  // Each stage samples the one before it, on the receiver's own edge.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stg_d[i] = d;
    end else begin : g_tail
      assign stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cdc_hs_launch.sv
module cdc_hs_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,     // level requested by the local system
  input  logic permit_i,  // a new rise may start only while this is high
  output logic q_o        // registered level that crosses the boundary
);

  logic q_nxt;
  logic q_en;

  // A fall always passes; a rise waits for permission; a held high stays.
  always_comb begin
    q_nxt = lvl_i & (q_o | permit_i);
    q_en  = q_nxt ^ q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_nxt;
  end

endmodule

// File: rtl/cdc_req_done_bridge.sv
module cdc_req_done_bridge #(
  parameter int unsigned SYNC_STAGES = cdc_hs_pkg::DEF_STAGES,
  parameter int unsigned RST_STAGES  = cdc_hs_pkg::DEF_STAGES
) (
  input  logic clk_a,
  input  logic rst_a_n,
  input  logic a_req_i,
  output logic a_done_o,
  input  logic clk_b,
  input  logic rst_b_n,
  output logic b_req_o,
  input  logic b_done_i
);

  localparam int unsigned SYNC_N = cdc_hs_pkg::clamp_stages(SYNC_STAGES);
  localparam int unsigned RST_N  = cdc_hs_pkg::clamp_stages(RST_STAGES);

  logic srst_a_n;
  logic srst_b_n;
  logic req_launch;
  logic done_launch;
  logic req_permit;

  // Local reset release per domain.
  cdc_hs_rst_sync #(.STAGES(RST_N)) u_rst_a (
    .clk    (clk_a),
    .arst_n (rst_a_n),
    .srst_n (srst_a_n)
  );

  cdc_hs_rst_sync #(.STAGES(RST_N)) u_rst_b (
    .clk    (clk_b),
    .arst_n (rst_b_n),
    .srst_n (srst_b_n)
  );

  // Domain A: request launch, held off while old done is still high.
  assign req_permit = ~a_done_o;

  cdc_hs_launch u_req_launch (
    .clk      (clk_a),
    .rst_n    (srst_a_n),
    .lvl_i    (a_req_i),
    .permit_i (req_permit),
    .q_o      (req_launch)
  );

  // Request resampled by domain B's clock.
  cdc_hs_sync_chain #(.STAGES(SYNC_N)) u_req_sync (
    .clk   (clk_b),
    .rst_n (srst_b_n),
    .d     (req_launch),
    .q     (b_req_o)
  );

  // Domain B: done launch, allowed to rise only while request is present.
  cdc_hs_launch u_done_launch (
    .clk      (clk_b),
    .rst_n    (srst_b_n),
    .lvl_i    (b_done_i),
    .permit_i (b_req_o),
    .q_o      (done_launch)
  );

  // Done resampled by domain A's clock.
  cdc_hs_sync_chain #(.STAGES(SYNC_N)) u_done_sync (
    .clk   (clk_a),
    .rst_n (srst_a_n),
    .d     (done_launch),
    .q     (a_done_o)
  );

endmodule

// File: rtl/cdc_hs_checker.sv
module cdc_hs_checker (
  input logic clk_a,
  input logic clk_b,
  input logic rst_a_n,
  input logic rst_b_n,
  input logic srst_a_n,
  input logic srst_b_n,
  input logic a_req_i,
  input logic a_done_o,
  input logic b_req_o,
  input logic b_done_i,
  input logic req_launch,
  input logic done_launch
);

  AST_REQ_IN_RESET: assert property (@(posedge clk_b) !rst_b_n |-> !b_req_o); // R1
  AST_DONE_IN_RESET: assert property (@(posedge clk_a) !rst_a_n |-> !a_done_o); // R1

  AST_REQ_HOLD: assert property (@(posedge clk_a) disable iff (!srst_a_n)
    (req_launch && a_req_i) |=> req_launch); // R2
  AST_REQ_DROP: assert property (@(posedge clk_a) disable iff (!srst_a_n)
    !a_req_i |=> !req_launch); // R3
  AST_DONE_HOLD: assert property (@(posedge clk_b) disable iff (!srst_b_n)
    (done_launch && b_done_i) |=> done_launch); // R4
  AST_DONE_DROP: assert property (@(posedge clk_b) disable iff (!srst_b_n)
    !b_done_i |=> !done_launch); // R5
  AST_REQ_GUARD: assert property (@(posedge clk_a) disable iff (!srst_a_n)
    $rose(req_launch) |-> $past(!a_done_o)); // R6
  AST_DONE_GUARD: assert property (@(posedge clk_b) disable iff (!srst_b_n)
    $rose(done_launch) |-> $past(b_req_o)); // R7

endmodule

bind cdc_req_done_bridge cdc_hs_checker u_chk (
  .clk_a       (clk_a),
  .clk_b       (clk_b),
  .rst_a_n     (rst_a_n),
  .rst_b_n     (rst_b_n),
  .srst_a_n    (srst_a_n),
  .srst_b_n    (srst_b_n),
  .a_req_i     (a_req_i),
  .a_done_o    (a_done_o),
  .b_req_o     (b_req_o),
  .b_done_i    (b_done_i),
  .req_launch  (req_launch),
  .done_launch (done_launch)
);

// File: tb/sim_cdc_req_done_bridge.sv
`timescale 1ns/1ps
module sim_cdc_req_done_bridge;

  localparam int N = 2;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_a_n = 1'b0;
  logic rst_b_n = 1'b0;
  logic a_req_i = 1'b0;
  logic b_done_i = 1'b0;
  logic a_done_o;
  logic b_req_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  bit exp_req_q[$];
  bit exp_done_q[$];
  bit prev_req = 1'b0;
  bit prev_done = 1'b0;

  always #5   clk_a = ~clk_a;
  always #3.6 clk_b = ~clk_b;

  cdc_req_done_bridge u0 (
    .clk_a    (clk_a),
    .rst_a_n  (rst_a_n),
    .a_req_i  (a_req_i),
    .a_done_o (a_done_o),
    .clk_b    (clk_b),
    .rst_b_n  (rst_b_n),
    .b_req_o  (b_req_o),
    .b_done_i (b_done_i)
  );

  task automatic check_eq(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic check_range(input string r, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", r, act, lo, hi);
    end
  endtask

  // Monitors: every edge seen must match the next expected level (R8).
  always @(negedge clk_b) begin
    if (mon_on && b_req_o !== prev_req) begin
      checks++;
      if (exp_req_q.size() == 0) begin
        fails++;
        $display("FAIL R8: b_req_o unexpected edge, actual %0d expected no change", b_req_o);
      end else begin
        bit e;
        e = exp_req_q.pop_front();
        if (e !== b_req_o) begin
          fails++;
          $display("FAIL R8: b_req_o edge actual %0d expected %0d", b_req_o, e);
        end
      end
      prev_req = b_req_o;
    end
  end

  always @(negedge clk_a) begin
    if (mon_on && a_done_o !== prev_done) begin
      checks++;
      if (exp_done_q.size() == 0) begin
        fails++;
        $display("FAIL R8: a_done_o unexpected edge, actual %0d expected no change", a_done_o);
      end else begin
        bit e;
        e = exp_done_q.pop_front();
        if (e !== a_done_o) begin
          fails++;
          $display("FAIL R8: a_done_o edge actual %0d expected %0d", a_done_o, e);
        end
      end
      prev_done = a_done_o;
    end
  end

  task automatic wait_breq(input bit v, output int n);
    n = 0;
    while (b_req_o !== v && n < 100) begin
      @(posedge clk_b); #1; n++;
    end
  endtask

  task automatic wait_adone(input bit v, output int n);
    n = 0;
    while (a_done_o !== v && n < 100) begin
      @(posedge clk_a); #1; n++;
    end
  endtask

  // Driver: pushes the expected edge, then drives the level.
  task automatic drive_req(input bit v);
    exp_req_q.push_back(v);
    @(negedge clk_a); a_req_i = v;
  endtask

  task automatic drive_done(input bit v);
    exp_done_q.push_back(v);
    @(negedge clk_b); b_done_i = v;
  endtask

  task automatic full_cycle(input int gap);
    int n;
    drive_req(1'b1);
    wait_breq(1'b1, n);
    check_range("R2 request rise latency", n, N, N+3);
    repeat (gap) @(negedge clk_b);
    drive_done(1'b1);
    wait_adone(1'b1, n);
    check_range("R4 done rise latency", n, N, N+3);
    repeat (gap) @(negedge clk_a);
    drive_req(1'b0);
    wait_breq(1'b0, n);
    check_range("R3 request fall latency", n, N, N+3);
    drive_done(1'b0);
    wait_adone(1'b0, n);
    check_range("R5 done fall latency", n, N, N+3);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    #42;
    check_eq("R1 b_req_o in reset", int'(b_req_o), 0);
    check_eq("R1 a_done_o in reset", int'(a_done_o), 0);
    #60;
    rst_a_n = 1'b1;
    #3;
    rst_b_n = 1'b1;
    repeat (10) @(negedge clk_a);
    check_eq("R1 b_req_o after release", int'(b_req_o), 0);
    check_eq("R1 a_done_o after release", int'(a_done_o), 0);
    mon_on = 1'b1;

    // R2..R5, R8: cycles with different response gaps
    for (int g = 0; g < 4; g++) full_cycle(g * 3);

    // R6: new request while done still high
    drive_req(1'b1);
    wait_breq(1'b1, n);
    drive_done(1'b1);
    wait_adone(1'b1, n);
    drive_req(1'b0);
    wait_breq(1'b0, n);
    @(negedge clk_a); a_req_i = 1'b1;
    repeat (20) @(negedge clk_b);
    check_eq("R6 early request held off", int'(b_req_o), 0);
    exp_req_q.push_back(1'b1);
    drive_done(1'b0);
    wait_adone(1'b0, n);
    wait_breq(1'b1, n);
    check_range("R6 released request latency", n, N, N+3);
    drive_done(1'b1);
    wait_adone(1'b1, n);
    drive_req(1'b0);
    wait_breq(1'b0, n);
    drive_done(1'b0);
    wait_adone(1'b0, n);

    // R7: done raised with no request present
    @(negedge clk_b); b_done_i = 1'b1;
    repeat (20) @(negedge clk_a);
    check_eq("R7 early done held off", int'(a_done_o), 0);
    exp_done_q.push_back(1'b1);
    drive_req(1'b1);
    wait_breq(1'b1, n);
    wait_adone(1'b1, n);
    check_range("R7 released done latency", n, N, N+3);
    drive_req(1'b0);
    wait_breq(1'b0, n);
    drive_done(1'b0);
    wait_adone(1'b0, n);

    repeat (10) @(negedge clk_a);
    check_eq("R8 request queue drained", exp_req_q.size(), 0);
    check_eq("R8 done queue drained", exp_done_q.size(), 0);
    check_eq("R8 b_req_o idle", int'(b_req_o), 0);
    check_eq("R8 a_done_o idle", int'(a_done_o), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule